// File: doc/BRIEF.md
# Three-Wire SPI Accelerometer Poller

This block brings up a three-axis digital accelerometer over a serial link whose single data wire carries traffic in both directions, and then keeps it sampled. After reset it sends three register writes: the first switches the sensor into single-wire mode and selects a 10-bit, right-aligned, ±2 g output. The second selects a 400 Hz output rate. The third starts measurement. No read is issued before the mode switch.

From then on the block reads the sensor's interrupt-source register over and over until the data-ready flag is set. It then fetches the six output bytes in a single multi-byte burst and rebuilds the three signed axis values. All three axis outputs change in the same cycle, and a one-cycle strobe marks them. The host side needs only the three axis outputs and the strobe. On the wire side, the data line is split into an output value, an output enable and an input value, and the pad logic joins them.

Top module: `accel3w_poller`

## Requirements
- R1: Out of reset and between transactions, chip select is high, the serial clock is high and the data output enable is low.
- R2: The first byte of every transaction is a command byte: bit 7 = 1 for a read, bit 6 = 1 for a multi-byte access, and bits 5..0 hold the register address. It is sent most significant bit first.
- R3: The serial clock idles high. The block changes its data output only on falling serial-clock edges, samples the input on rising edges, and holds chip select low from the first clock to the last.
- R4: The first transaction is a write of 0x40 to register 0x31. This value sets bit 6 (single-wire mode) and clears bit 3 (10-bit resolution), bit 2 (right-justified) and bits 1..0 (±2 g). No read occurs before this write.
- R5: Next, 0x0C is written to register 0x2C (400 Hz), then 0x08 to register 0x2D (measure). These are the only writes.
- R6: On a read, the block drives the line for the eight command bits only. It releases the line at the ninth falling edge and does not drive it while the sensor returns data.
- R7: A poll is a single-byte read of register 0x30 (command byte 0xB0). Only bit 7 of the returned byte is the data-ready flag, and the other seven bits are ignored. Polls repeat while bit 7 is 0.
- R8: A sample burst (command byte 0xF2: read, multi-byte, address 0x32) returns six bytes and is issued only after a poll that returned data-ready set.
- R9: The six bytes are taken in the order X low, X high, Y low, Y high, Z low, Z high. Each axis is {high[1:0], low[7:0]} read as two's complement, and bits 7..2 of each high byte are ignored.
- R10: After each burst, the three axis outputs change together in one cycle, and the valid strobe is high for exactly that one cycle. At all other times the outputs hold their values.
- R11: After each burst the block returns to polling, so each further sample needs its own data-ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | output | 1 | Sensor chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| sdio_o | output | 1 | Value driven onto the shared data line |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| sdio_i | input | 1 | Value seen on the shared data line |
| accel_x | output | 10 | Signed X-axis sample |
| accel_y | output | 10 | Signed Y-axis sample |
| accel_z | output | 10 | Signed Z-axis sample |
| sample_valid | output | 1 | One-cycle strobe when all three axes update |

## Verification
The hardest moment to reach from the ports is the handover of the shared data line at the ninth falling edge. Both sides switch at that same edge, so a one-edge slip shows up only as a short overlap or as a garbled first returned bit. The bench therefore contains a bit-level sensor model that starts driving exactly at that edge and flags any cycle in which both sides drive. The model also delays data-ready by a random number of polls (zero to three) and returns 0x7F while not ready, so the flag bit alone must gate the burst. Directed full-scale samples (+511, -512, -1, 0) come first. They are followed by random samples whose high bytes carry junk in bits 7..2 on alternate samples.

// File: rtl/accel3w_pkg.sv
package accel3w_pkg;

    localparam int BYTE_W      = 8;
    localparam int AXIS_W      = 10;
    localparam int N_AXES      = 3;
    localparam int BURST_BYTES = 2 * N_AXES;

    localparam logic [5:0] REG_FORMAT = 6'h31;
    localparam logic [7:0] VAL_FORMAT = 8'h40;  // single-wire, 10-bit, right, +-2g
    localparam logic [5:0] REG_RATE   = 6'h2C;
    localparam logic [7:0] VAL_RATE   = 8'h0C;  // 400 Hz
    localparam logic [5:0] REG_POWER  = 6'h2D;
    localparam logic [7:0] VAL_POWER  = 8'h08;  // measure
    localparam logic [5:0] REG_ISRC   = 6'h30;
    localparam int         READY_BIT  = 7;
    localparam logic [5:0] REG_DATA0  = 6'h32;

    typedef enum logic [2:0] {
        STEP_FORMAT, STEP_RATE, STEP_POWER, STEP_POLL, STEP_BURST
    } step_e;

    typedef enum logic [2:0] {
        ENG_IDLE, ENG_LEAD, ENG_LOW, ENG_HIGH, ENG_TRAIL
    } eng_state_e;

    typedef struct packed {
        logic             rd;
        logic             multi;
        logic [5:0]       addr;
        logic [BYTE_W-1:0] wdata;
        logic [2:0]       nbytes;
    } xfer_t;

    function automatic xfer_t xfer_for(step_e s);
        xfer_t x;
        x = '{rd: 1'b0, multi: 1'b0, addr: 6'h00, wdata: 8'h00, nbytes: 3'd1};
        case (s)
            STEP_FORMAT: begin x.addr = REG_FORMAT; x.wdata = VAL_FORMAT; end
            STEP_RATE:   begin x.addr = REG_RATE;   x.wdata = VAL_RATE;   end
            STEP_POWER:  begin x.addr = REG_POWER;  x.wdata = VAL_POWER;  end
            STEP_POLL:   begin x.rd = 1'b1; x.addr = REG_ISRC; end
            default:     begin x.rd = 1'b1; x.multi = 1'b1; x.addr = REG_DATA0;
                               x.nbytes = 3'(BURST_BYTES); end
        endcase
        return x;
    endfunction

    function automatic logic [AXIS_W-1:0] axis_join(logic [BYTE_W-1:0] lo,
                                                    logic [BYTE_W-1:0] hi);
        return {hi[AXIS_W-BYTE_W-1:0], lo};
    endfunction

endpackage

// File: rtl/accel3w_spi_engine.sv
module accel3w_spi_engine
    import accel3w_pkg::*;
#(
    parameter int CLK_DIV   = 25,
    parameter int MAX_BYTES = BURST_BYTES
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  xfer_t                         req,
    output logic                          done,
    output logic [MAX_BYTES*BYTE_W-1:0]   rx_data,
    output logic                          cs_n,
    output logic                          sclk,
    output logic                          sdo,
    output logic                          sdo_oe,
    input  logic                          sdi
);
    localparam int DIV_W   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int MAXBITS = (MAX_BYTES + 1) * BYTE_W;
    localparam int BIT_W   = $clog2(MAXBITS + 1);
    localparam int SH_W    = 2 * BYTE_W;

    eng_state_e        state;
    logic [DIV_W-1:0]  div_cnt;
    logic [BIT_W-1:0]  bit_idx, last_bit;
    logic [SH_W-1:0]   shreg;
    logic              is_rd;
    logic              tick;

    assign tick = (div_cnt == DIV_W'(CLK_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ENG_IDLE;
            div_cnt  <= '0;
            bit_idx  <= '0;
            last_bit <= '0;
            shreg    <= '0;
            is_rd    <= 1'b0;
            rx_data  <= '0;
            cs_n     <= 1'b1;
            sclk     <= 1'b1;
            sdo      <= 1'b0;
            sdo_oe   <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state != ENG_IDLE)
                div_cnt <= tick ? '0 : div_cnt + 1'b1;
            case (state)
                ENG_IDLE: if (start) begin
                    cs_n     <= 1'b0;
                    is_rd    <= req.rd;
                    shreg    <= {req.rd, req.multi, req.addr,
                                 req.rd ? {BYTE_W{1'b0}} : req.wdata};
                    last_bit <= req.rd ? BIT_W'(BYTE_W * (int'(req.nbytes) + 1) - 1)
                                       : BIT_W'(SH_W - 1);
                    bit_idx  <= '0;
                    div_cnt  <= '0;
                    state    <= ENG_LEAD;
                end
                ENG_LEAD: if (tick) begin
                    sclk   <= 1'b0;
                    sdo    <= shreg[SH_W-1];
                    shreg  <= shreg << 1;
                    sdo_oe <= 1'b1;
                    state  <= ENG_LOW;
                end
                ENG_LOW: if (tick) begin
                    sclk <= 1'b1;
                    if (is_rd && bit_idx >= BIT_W'(BYTE_W))
                        rx_data <= {rx_data[MAX_BYTES*BYTE_W-2:0], sdi};
                    state <= ENG_HIGH;
                end
                ENG_HIGH: if (tick) begin
                    if (bit_idx == last_bit) begin
                        state <= ENG_TRAIL;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        sclk    <= 1'b0;
                        sdo     <= shreg[SH_W-1];
                        shreg   <= shreg << 1;
                        sdo_oe  <= !(is_rd && bit_idx >= BIT_W'(BYTE_W - 1));
                        state   <= ENG_LOW;
                    end
                end
                ENG_TRAIL: if (tick) begin
                    cs_n   <= 1'b1;
                    sdo_oe <= 1'b0;
                    done   <= 1'b1;
                    state  <= ENG_IDLE;
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/accel3w_sequencer.sv
module accel3w_sequencer
    import accel3w_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            done,
    input  logic [BURST_BYTES*BYTE_W-1:0]   rx_data,
    output logic                            start,
    output xfer_t                           req,
    output logic [AXIS_W-1:0]               axis_x,
    output logic [AXIS_W-1:0]               axis_y,
    output logic [AXIS_W-1:0]               axis_z,
    output logic                            valid
);
    step_e                step;
    logic                 waiting;
    logic [AXIS_W-1:0]    axis_q [N_AXES];
    logic [AXIS_W-1:0]    axis_new [N_AXES];

    assign req = xfer_for(step);

    // byte k of the burst arrived k-th, so it sits k bytes below the top
    for (genvar a = 0; a < N_AXES; a++) begin : g_axis
        localparam int LO_POS = (BURST_BYTES - 1 - 2 * a) * BYTE_W;
        localparam int HI_POS = (BURST_BYTES - 2 - 2 * a) * BYTE_W;
        assign axis_new[a] = axis_join(rx_data[LO_POS +: BYTE_W],
                                       rx_data[HI_POS +: BYTE_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step    <= STEP_FORMAT;
            waiting <= 1'b0;
            start   <= 1'b0;
            valid   <= 1'b0;
            for (int a = 0; a < N_AXES; a++) axis_q[a] <= '0;
        end else begin
            start <= 1'b0;
            valid <= 1'b0;
            if (!waiting) begin
                start   <= 1'b1;
                waiting <= 1'b1;
            end else if (done) begin
                waiting <= 1'b0;
                case (step)
                    STEP_FORMAT: step <= STEP_RATE;
                    STEP_RATE:   step <= STEP_POWER;
                    STEP_POWER:  step <= STEP_POLL;
                    STEP_POLL:   step <= rx_data[READY_BIT] ? STEP_BURST : STEP_POLL;
                    default: begin
                        for (int a = 0; a < N_AXES; a++) axis_q[a] <= axis_new[a];
                        valid <= 1'b1;
                        step  <= STEP_POLL;
                    end
                endcase
            end
        end
    end

    assign axis_x = axis_q[0];
    assign axis_y = axis_q[1];
    assign axis_z = axis_q[2];
endmodule

// File: rtl/accel3w_poller.sv
module accel3w_poller
    import accel3w_pkg::*;
#(
    parameter int CLK_DIV = 25
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cs_n,
    output logic              sclk,
    output logic              sdio_o,
    output logic              sdio_oe,
    input  logic              sdio_i,
    output logic [AXIS_W-1:0] accel_x,
    output logic [AXIS_W-1:0] accel_y,
    output logic [AXIS_W-1:0] accel_z,
    output logic              sample_valid
);
    logic                          xfer_start, xfer_done;
    xfer_t                         xfer_req;
    logic [BURST_BYTES*BYTE_W-1:0] xfer_rx;

    accel3w_spi_engine #(.CLK_DIV(CLK_DIV), .MAX_BYTES(BURST_BYTES)) u_engine (
        .clk(clk), .rst(rst), .start(xfer_start), .req(xfer_req),
        .done(xfer_done), .rx_data(xfer_rx), .cs_n(cs_n), .sclk(sclk),
        .sdo(sdio_o), .sdo_oe(sdio_oe), .sdi(sdio_i)
    );

    accel3w_sequencer u_seq (
        .clk(clk), .rst(rst), .done(xfer_done), .rx_data(xfer_rx),
        .start(xfer_start), .req(xfer_req), .axis_x(accel_x),
        .axis_y(accel_y), .axis_z(accel_z), .valid(sample_valid)
    );
endmodule

// File: rtl/accel3w_poller_chk.sv
module accel3w_poller_chk
    import accel3w_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              sclk,
    input logic              sdio_o,
    input logic              sdio_oe,
    input logic [AXIS_W-1:0] accel_x,
    input logic [AXIS_W-1:0] accel_y,
    input logic [AXIS_W-1:0] accel_z,
    input logic              sample_valid
);
    // R1
    idle_clock_high_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sclk);
    // R3
    clock_low_inside_frame_chk: assert property (@(posedge clk) disable iff (rst)
        !sclk |-> !cs_n);
    // R3
    data_moves_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sdio_o) && !cs_n) |-> !sclk);
    // R6
    drive_only_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        sdio_oe |-> !cs_n);
    // R10
    valid_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);
    // R10
    axes_change_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(accel_x) || !$stable(accel_y) || !$stable(accel_z)) |-> sample_valid);
endmodule

bind accel3w_poller accel3w_poller_chk u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdio_o(sdio_o),
    .sdio_oe(sdio_oe), .accel_x(accel_x), .accel_y(accel_y),
    .accel_z(accel_z), .sample_valid(sample_valid)
);

// File: tb/accel3w_poller_bench.sv
module accel3w_poller_bench;
    localparam int NS    = 12;
    localparam int LIMIT = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic       cs_n, sclk, sdio_o, sdio_oe;
    logic [9:0] ax, ay, az;
    logic       valid;
    logic       drv = 1'b0, drv_bit = 1'b1;
    logic       sdio_i;

    assign sdio_i = sdio_oe ? sdio_o : (drv ? drv_bit : 1'b1);

    accel3w_poller #(.CLK_DIV(2)) u_accel3w_poller (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdio_o(sdio_o),
        .sdio_oe(sdio_oe), .sdio_i(sdio_i), .accel_x(ax), .accel_y(ay),
        .accel_z(az), .sample_valid(valid)
    );

    int checks = 0, errors = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- sensor model ----------------
    logic [7:0] mem [0:63];
    logic [7:0] hdr = 8'h00, wbyte = 8'h00;
    int  cnt = 0;
    int  nwrites = 0, nbursts = 0, nloaded = 0, polls = 0, wait_target = 1;
    bit  fmt_done = 0, dr_seen = 0;
    logic [9:0] exp_v [NS][3];
    logic [7:0] wr_addr_exp [3] = '{8'h31, 8'h2C, 8'h2D};
    logic [7:0] wr_val_exp  [3] = '{8'h40, 8'h0C, 8'h08};

    function automatic logic [9:0] pick_value(int k, int a);
        logic [9:0] d [4] = '{10'h1FF, 10'h200, 10'h3FF, 10'h000};
        if (k < 4) return d[(k + a) % 4];
        return 10'($urandom);
    endfunction

    task automatic load_sample();
        for (int a = 0; a < 3; a++) begin
            logic [9:0] v;
            logic [5:0] top;
            v = pick_value(nloaded, a);
            top = nloaded[0] ? 6'($urandom) : {6{v[9]}};
            exp_v[nloaded][a] = v;
            mem[6'h32 + 6'(2 * a)] = v[7:0];
            mem[6'h33 + 6'(2 * a)] = {top, v[9:8]};
        end
        mem[6'h30] = 8'h80 | 8'($urandom % 128);
        nloaded++;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'h00;
        mem[6'h30] = 8'h7F;
    end

    always @(negedge cs_n) begin
        cnt = 0; hdr = 8'h00; wbyte = 8'h00;
    end

    always @(posedge sclk) if (!cs_n) begin
        if (cnt < 8) hdr = {hdr[6:0], sdio_o};
        else if (!hdr[7] && cnt < 16) wbyte = {wbyte[6:0], sdio_o};
        cnt++;
        if (cnt == 8 && hdr[7]) begin
            // R4 no read before the format write
            check(fmt_done, "R4", hdr, 8'h31);
            if (hdr[5:0] == 6'h30) check(hdr == 8'hB0, "R7", hdr, 8'hB0);
            else if (hdr[5:0] == 6'h32) begin
                check(hdr == 8'hF2, "R8", hdr, 8'hF2);
                check(dr_seen, "R8", 0, 1);   // burst only after data-ready
                dr_seen = 0;
            end else check(0, "R2", hdr, 8'hB0);
        end
        if (cnt == 16 && !hdr[7]) begin
            if (nwrites < 3) begin
                check(hdr == {2'b00, wr_addr_exp[nwrites][5:0]},
                      nwrites == 0 ? "R4" : "R5", hdr, wr_addr_exp[nwrites]);
                check(wbyte == wr_val_exp[nwrites],
                      nwrites == 0 ? "R4" : "R5", wbyte, wr_val_exp[nwrites]);
                if (nwrites == 0) fmt_done = 1;
            end else check(0, "R5", hdr, 0);
            nwrites++;
        end
    end

    always @(negedge sclk) if (!cs_n && hdr[7] && cnt >= 8) begin
        int idx, b;
        idx = (cnt - 8) / 8;
        b   = 7 - ((cnt - 8) % 8);
        drv     = 1'b1;
        drv_bit = mem[hdr[5:0] + (hdr[6] ? 6'(idx) : 6'd0)][b];
    end

    always @(posedge cs_n) begin
        drv = 1'b0;
        if (hdr[7] && hdr[5:0] == 6'h30) begin
            if (mem[6'h30][7]) dr_seen = 1;
            else begin
                polls++;
                if (polls > wait_target && nloaded < NS) load_sample();
            end
        end else if (hdr[7] && hdr[5:0] == 6'h32) begin
            nbursts++;
            mem[6'h30]  = 8'h7F;
            polls       = 0;
            wait_target = $urandom % 4;
        end
    end

    // ---------------- output monitors ----------------
    int  nvalid = 0;
    bit  prev_valid = 0;
    int  contention = 0, idle_bad = 0;

    always @(negedge clk) if (!rst) begin
        if (sdio_oe && drv) contention++;
        if (cs_n && (!sclk || sdio_oe)) idle_bad++;
        if (valid) begin
            check(!prev_valid, "R10", 1, 0);
            if (nvalid < NS) begin
                check(ax == exp_v[nvalid][0], "R9 x", ax, exp_v[nvalid][0]);
                check(ay == exp_v[nvalid][1], "R9 y", ay, exp_v[nvalid][1]);
                check(az == exp_v[nvalid][2], "R9 z", az, exp_v[nvalid][2]);
            end
            nvalid++;
        end
        prev_valid = valid;
    end

    // ---------------- main ----------------
    initial begin
        int cyc;
        void'($urandom(32'd20240611));
        repeat (8) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(cs_n == 1'b1 && sclk == 1'b1 && sdio_oe == 1'b0, "R1",
              {cs_n, sclk, sdio_oe}, 3'b110);
        check(valid == 1'b0, "R10", valid, 0);
        rst = 1'b0;
        cyc = 0;
        while (nvalid < NS && cyc < LIMIT) begin
            @(posedge clk);
            cyc++;
        end
        check(cyc < LIMIT, "watchdog", cyc, LIMIT);
        repeat (200) @(posedge clk);
        @(negedge clk);
        check(contention == 0, "R6", contention, 0);
        check(idle_bad == 0, "R1", idle_bad, 0);
        check(nwrites == 3, "R5", nwrites, 3);
        check(nbursts == NS, "R11", nbursts, NS);
        check(nvalid == NS, "R10", nvalid, NS);
        // R3: values read back intact prove rising-edge sampling of falling-edge data
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule